// File: doc/BRIEF.md
# Rejected-Interrupt Record and Replay Unit

This unit sits beside an interrupt source controller and keeps a record of every interrupt that the presenter turned away. Each rejection carries a global interrupt number; the unit subtracts the controller's base number to get a local source index and marks that source in a two-level record: 32 words of 64 flags each, plus a 32-bit summary that has one flag per word holding at least one mark.

When the presenter later asks for a resend, the unit walks the summary upward from word 0. For each marked word it clears the summary flag, then walks the word's flags upward from bit 0. Each mark is cleared as it is claimed, and the source index (word × 64 + bit) is offered on a valid/ready output as a forced retrigger request. A forced request tells the trigger engine to treat the source's pending/queued state as 00. Only one request is in flight at a time. The scan does not move on until the request is accepted.

The controller is an FSM with four states. IDLE waits for a resend. SEL_WORD finds the next marked summary flag at or above the word cursor, clears it and enters SCAN_BIT; if there is none, the scan ends and the FSM returns to IDLE. SCAN_BIT finds the next marked bit at or above the bit cursor, clears it and enters EMIT; if there is none, it advances to the next word (SEL_WORD) or, after the last word, to IDLE. EMIT holds the request until it is accepted. It then returns to SCAN_BIT, or after bit 63 goes to the next word.

Top module: `rej_replay_top`

## Requirements
- R1: A rejection with `rej_irq` ≥ `rej_base` and `rej_irq − rej_base` < 2048 records source `rej_irq − rej_base`. The next resend emits exactly that value on `out_src`.
- R2: A rejection with `rej_irq` < `rej_base`, or with `rej_irq − rej_base` ≥ 2048, is dropped, and the next resend emits nothing.
- R3: A resend while nothing is recorded emits no request, and `busy` stays low.
- R4: A scan emits the recorded sources in strictly ascending source order: by word from 0 to 31, and within a word by bit from 0 to 63.
- R5: Every recorded source is cleared when it is claimed. A second resend after a complete scan emits nothing.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_src` holds its value, and the scan does not advance.
- R7: `busy` is high from the cycle after an accepted resend until the scan ends, and it is high whenever `out_valid` is high. A resend that arrives while `busy` is high is ignored.
- R8: A rejection that arrives during a scan is always recorded. If its position is still ahead of the scan, it is emitted in the same scan. If the scan has already passed it, it is emitted by the next resend.
- R9: Reset clears every word and the summary, so a resend after reset emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rej_valid | input | 1 | A rejection is presented this cycle |
| rej_irq | input | 16 | Global number of the rejected interrupt |
| rej_base | input | 16 | First global number owned by this controller |
| resend | input | 1 | Request a replay of all recorded sources |
| out_ready | input | 1 | The trigger engine accepts the current request |
| out_valid | output | 1 | A forced retrigger request is offered |
| out_src | output | 11 | Local source index of the offered request |
| busy | output | 1 | A scan is in progress |

## Verification
The bench builds the unit with its default sizes: 32 words of 64 bits, 16-bit interrupt numbers and 11-bit source indices. These sizes put both ends of the range within reach, source 0 and source 2047, as well as the first index past the range, which must be dropped. They also make it possible to test the boundaries between words, at bits 63 and 64. With back-pressure that is held or pseudo-random, the bench observes the ascending order across several words and the stall behaviour. It injects rejections during a stalled scan, both behind the scan and ahead of it, so both branches of R8 are exercised.

// File: rtl/rej_replay_pkg.sv
package rej_replay_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEL_WORD,
        ST_SCAN_BIT,
        ST_EMIT
    } replay_state_e;

endpackage

// File: rtl/lsb_find.sv
module lsb_find #(
    parameter int W     = 64,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    input  logic [IDX_W-1:0] lo,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // lowest set bit of vec whose position is at or above lo
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i] && (i >= int'(lo))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rej_bitmap.sv
module rej_bitmap #(
    parameter int NUM_WORDS = 32,
    parameter int WORD_BITS = 64,
    localparam int WIDX_W   = $clog2(NUM_WORDS),
    localparam int BIDX_W   = $clog2(WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [WIDX_W-1:0]    set_word,
    input  logic [BIDX_W-1:0]    set_bit,
    input  logic                 sum_clr_en,
    input  logic [WIDX_W-1:0]    sum_clr_idx,
    input  logic                 bit_clr_en,
    input  logic [WIDX_W-1:0]    bit_clr_word,
    input  logic [BIDX_W-1:0]    bit_clr_bit,
    input  logic [WIDX_W-1:0]    rd_word,
    output logic [NUM_WORDS-1:0] summary,
    output logic [WORD_BITS-1:0] rd_data
);
    logic [WORD_BITS-1:0] words_q [NUM_WORDS];
    logic [NUM_WORDS-1:0] sum_q;
    logic [WORD_BITS-1:0] bit_set_mask;
    logic [WORD_BITS-1:0] bit_clr_mask;

    assign bit_set_mask = WORD_BITS'(1) << set_bit;
    assign bit_clr_mask = WORD_BITS'(1) << bit_clr_bit;

    // a new mark always wins over a clear in the same cycle
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit_set;
        logic hit_clr;
        assign hit_set = set_en && (set_word == WIDX_W'(w));
        assign hit_clr = bit_clr_en && (bit_clr_word == WIDX_W'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[w] <= '0;
            end else begin
                words_q[w] <= (words_q[w] & ~(hit_clr ? bit_clr_mask : '0))
                            | (hit_set ? bit_set_mask : '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= (sum_q & ~(sum_clr_en ? (NUM_WORDS'(1) << sum_clr_idx) : '0))
                   | (set_en ? (NUM_WORDS'(1) << set_word) : '0);
        end
    end

    assign summary = sum_q;
    assign rd_data = words_q[rd_word];

    AST_MARK_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (sum_q[$past(set_word)] && words_q[$past(set_word)][$past(set_bit)])); // R8

    AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_clr_en && !(set_en && set_word == bit_clr_word && set_bit == bit_clr_bit))
        |=> !words_q[$past(bit_clr_word)][$past(bit_clr_bit)]); // R5
endmodule

// File: rtl/replay_fsm.sv
module replay_fsm
    import rej_replay_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int WORD_BITS = 64,
    localparam int WIDX_W   = $clog2(NUM_WORDS),
    localparam int BIDX_W   = $clog2(WORD_BITS),
    localparam int SRC_W    = WIDX_W + BIDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 resend,
    input  logic [NUM_WORDS-1:0] summary,
    input  logic [WORD_BITS-1:0] word_data,
    input  logic                 out_ready,
    output logic [WIDX_W-1:0]    rd_word,
    output logic                 sum_clr_en,
    output logic [WIDX_W-1:0]    sum_clr_idx,
    output logic                 bit_clr_en,
    output logic [WIDX_W-1:0]    bit_clr_word,
    output logic [BIDX_W-1:0]    bit_clr_bit,
    output logic                 out_valid,
    output logic [SRC_W-1:0]     out_src,
    output logic                 busy
);
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NUM_WORDS - 1);
    localparam logic [BIDX_W-1:0] LAST_BIT  = BIDX_W'(WORD_BITS - 1);

    replay_state_e state_q, state_d;
    logic [WIDX_W-1:0] word_ptr_q, word_idx_q;
    logic [BIDX_W-1:0] bit_ptr_q;
    logic [SRC_W-1:0]  src_q;
    logic              wfound, bfound;
    logic [WIDX_W-1:0] widx;
    logic [BIDX_W-1:0] bidx;
    logic              fire;

    lsb_find #(.W(NUM_WORDS), .IDX_W(WIDX_W)) u_word_find (
        .vec(summary), .lo(word_ptr_q), .found(wfound), .idx(widx)
    );

    lsb_find #(.W(WORD_BITS), .IDX_W(BIDX_W)) u_bit_find (
        .vec(word_data), .lo(bit_ptr_q), .found(bfound), .idx(bidx)
    );

    assign fire = (state_q == ST_EMIT) && out_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (resend && (|summary)) state_d = ST_SEL_WORD;
            ST_SEL_WORD: state_d = wfound ? ST_SCAN_BIT : ST_IDLE;
            ST_SCAN_BIT: begin
                if (bfound)                       state_d = ST_EMIT;
                else if (word_idx_q == LAST_WORD) state_d = ST_IDLE;
                else                              state_d = ST_SEL_WORD;
            end
            ST_EMIT: begin
                if (fire) begin
                    if (src_q[BIDX_W-1:0] != LAST_BIT) state_d = ST_SCAN_BIT;
                    else if (word_idx_q == LAST_WORD)  state_d = ST_IDLE;
                    else                               state_d = ST_SEL_WORD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // scan cursors and held request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_ptr_q <= '0;
            word_idx_q <= '0;
            bit_ptr_q  <= '0;
            src_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: word_ptr_q <= '0;
                ST_SEL_WORD: begin
                    word_idx_q <= widx;
                    bit_ptr_q  <= '0;
                end
                ST_SCAN_BIT: begin
                    if (bfound) src_q <= {word_idx_q, bidx};
                    else if (word_idx_q != LAST_WORD) word_ptr_q <= word_idx_q + 1'b1;
                end
                ST_EMIT: begin
                    if (fire) begin
                        if (src_q[BIDX_W-1:0] != LAST_BIT)
                            bit_ptr_q <= src_q[BIDX_W-1:0] + 1'b1;
                        else if (word_idx_q != LAST_WORD)
                            word_ptr_q <= word_idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_word      = word_idx_q;
        sum_clr_en   = (state_q == ST_SEL_WORD) && wfound;
        sum_clr_idx  = widx;
        bit_clr_en   = (state_q == ST_SCAN_BIT) && bfound;
        bit_clr_word = word_idx_q;
        bit_clr_bit  = bidx;
        out_valid    = (state_q == ST_EMIT);
        out_src      = src_q;
        busy         = (state_q != ST_IDLE);
    end

    // order tracking for the ascending check
    logic [SRC_W-1:0] prev_src_q;
    logic             have_prev_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_src_q  <= '0;
            have_prev_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            have_prev_q <= 1'b0;
        end else if (fire) begin
            prev_src_q  <= src_q;
            have_prev_q <= 1'b1;
        end
    end

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && have_prev_q) |-> (src_q > prev_src_q)); // R4

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_src))); // R6

    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy); // R7

    AST_EMPTY_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        (resend && !busy && (summary == '0)) |=> !busy); // R3
endmodule

// File: rtl/rej_replay_top.sv
module rej_replay_top #(
    parameter int NUM_WORDS = 32,
    parameter int WORD_BITS = 64,
    parameter int IRQ_W     = 16,
    localparam int WIDX_W   = $clog2(NUM_WORDS),
    localparam int BIDX_W   = $clog2(WORD_BITS),
    localparam int SRC_W    = WIDX_W + BIDX_W,
    localparam int NUM_SRC  = NUM_WORDS * WORD_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rej_valid,
    input  logic [IRQ_W-1:0] rej_irq,
    input  logic [IRQ_W-1:0] rej_base,
    input  logic             resend,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [SRC_W-1:0] out_src,
    output logic             busy
);
    logic [IRQ_W-1:0]     rel;
    logic                 in_range;
    logic                 set_en;
    logic [SRC_W-1:0]     set_src;
    logic [NUM_WORDS-1:0] summary;
    logic [WORD_BITS-1:0] word_data;
    logic [WIDX_W-1:0]    rd_word;
    logic                 sum_clr_en, bit_clr_en;
    logic [WIDX_W-1:0]    sum_clr_idx, bit_clr_word;
    logic [BIDX_W-1:0]    bit_clr_bit;

    assign rel      = rej_irq - rej_base;
    assign in_range = (rej_irq >= rej_base) && ({1'b0, rel} < (IRQ_W + 1)'(NUM_SRC));
    assign set_en   = rej_valid && in_range;
    assign set_src  = rel[SRC_W-1:0];

    rej_bitmap #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_bitmap (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en),
        .set_word(set_src[SRC_W-1:BIDX_W]),
        .set_bit(set_src[BIDX_W-1:0]),
        .sum_clr_en(sum_clr_en), .sum_clr_idx(sum_clr_idx),
        .bit_clr_en(bit_clr_en), .bit_clr_word(bit_clr_word), .bit_clr_bit(bit_clr_bit),
        .rd_word(rd_word),
        .summary(summary), .rd_data(word_data)
    );

    replay_fsm #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .resend(resend),
        .summary(summary), .word_data(word_data),
        .out_ready(out_ready),
        .rd_word(rd_word),
        .sum_clr_en(sum_clr_en), .sum_clr_idx(sum_clr_idx),
        .bit_clr_en(bit_clr_en), .bit_clr_word(bit_clr_word), .bit_clr_bit(bit_clr_bit),
        .out_valid(out_valid), .out_src(out_src), .busy(busy)
    );

    AST_DROP_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_valid && (rej_irq < rej_base) && !busy && summary == '0) |=> (summary == '0)); // R2
endmodule

// File: tb/rej_replay_top_tb.sv
module rej_replay_top_tb;
    localparam int IRQ_W = 16;
    localparam int SRC_W = 11;

    typedef struct packed {
        logic [IRQ_W-1:0] base;
        logic [IRQ_W-1:0] irq;
        logic             hit;
        logic [SRC_W-1:0] src;
    } vec_t;

    // R1 hits and R2 drops
    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 16'h0000, 1'b1, 11'd0},
        '{16'h0100, 16'h013F, 1'b1, 11'd63},
        '{16'h0100, 16'h0140, 1'b1, 11'd64},
        '{16'h0020, 16'h081F, 1'b1, 11'd2047},
        '{16'h0020, 16'h0820, 1'b0, 11'd0},
        '{16'h0300, 16'h02FF, 1'b0, 11'd0},
        '{16'h0040, 16'h0428, 1'b1, 11'd1000}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rej_valid = 1'b0;
    logic [IRQ_W-1:0] rej_irq = '0;
    logic [IRQ_W-1:0] rej_base = '0;
    logic             resend = 1'b0;
    logic             out_ready = 1'b0;
    logic             out_valid;
    logic [SRC_W-1:0] out_src;
    logic             busy;

    int checks = 0;
    int errors = 0;
    int got_q[$];
    int exp_q[$];
    logic       rdy_random = 1'b0;
    logic       rdy_force  = 1'b1;
    logic [7:0] lfsr = 8'h5A;
    int         cycles = 0;

    always #5 clk = ~clk;

    rej_replay_top u_dut (
        .clk(clk), .rst_n(rst_n), .rej_valid(rej_valid), .rej_irq(rej_irq),
        .rej_base(rej_base), .resend(resend), .out_ready(out_ready),
        .out_valid(out_valid), .out_src(out_src), .busy(busy)
    );

    always @(posedge clk) begin
        #2;
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= rdy_random ? lfsr[0] : rdy_force;
    end

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && out_valid && out_ready) got_q.push_back(int'(out_src));
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reject(input int base, input int irq);
        @(negedge clk);
        rej_valid = 1'b1; rej_base = IRQ_W'(base); rej_irq = IRQ_W'(irq);
        @(negedge clk);
        rej_valid = 1'b0;
    endtask

    task automatic pulse_resend();
        @(negedge clk);
        resend = 1'b1;
        @(negedge clk);
        resend = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic compare(input string req);
        bit ok = (got_q.size() == exp_q.size());
        if (ok) foreach (exp_q[i]) if (got_q[i] != exp_q[i]) ok = 0;
        if (!ok) begin
            for (int i = 0; i < got_q.size(); i++) $display("  got[%0d]=%0d", i, got_q[i]);
            for (int i = 0; i < exp_q.size(); i++) $display("  exp[%0d]=%0d", i, exp_q[i]);
        end
        check(ok, req, got_q.size(), exp_q.size());
        got_q.delete();
        exp_q.delete();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !out_valid, "R9 reset state", int'(busy), 0);

        // table walk: R1 / R2
        for (int v = 0; v < NV; v++) begin
            reject(int'(VEC[v].base), int'(VEC[v].irq));
            if (VEC[v].hit) exp_q.push_back(int'(VEC[v].src));
            pulse_resend();
            wait_idle();
            compare(VEC[v].hit ? "R1 record/replay" : "R2 out-of-range drop");
        end

        // R3 empty resend
        @(negedge clk); resend = 1'b1;
        @(negedge clk); resend = 1'b0;
        check(!busy, "R3 busy after empty resend", int'(busy), 0);
        wait_idle();
        compare("R3 no emission");

        // R4 ascending order with random back-pressure
        rdy_random = 1'b1;
        reject(0, 2047); reject(0, 700); reject(0, 64);
        reject(0, 0); reject(0, 63); reject(0, 65);
        exp_q = '{0, 63, 64, 65, 700, 2047};
        pulse_resend();
        wait_idle();
        compare("R4 ascending order");
        rdy_random = 1'b0;

        // R5 second resend is empty
        pulse_resend();
        wait_idle();
        compare("R5 claimed sources cleared");

        // R6/R7/R8 stall and mid-scan rejections
        rdy_force = 1'b0;
        reject(0, 5); reject(0, 200);
        pulse_resend();
        for (int i = 0; i < 20 && !out_valid; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        check(out_valid && out_src == 11'd5, "R6 request held while stalled", int'(out_src), 5);
        check(busy, "R7 busy during scan", int'(busy), 1);
        reject(0, 2); reject(0, 130); reject(0, 6);
        @(negedge clk); resend = 1'b1;      // ignored while busy (R7)
        @(negedge clk); resend = 1'b0;
        rdy_force = 1'b1;
        wait_idle();
        check(!busy, "R7 busy low after scan", int'(busy), 0);
        exp_q = '{5, 6, 130, 200};
        compare("R8 late rejections ahead of scan");
        pulse_resend();
        wait_idle();
        exp_q = '{2};
        compare("R8 rejection behind scan waits");

        // R9 reset clears the record
        reject(0, 17); reject(0, 1500);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        pulse_resend();
        wait_idle();
        compare("R9 reset clears bitmap");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule